// File: doc/BRIEF.md
# Power-Sequencer Two-Wire Register Slave

This block is the two-wire slave port of a power sequencer. It watches an external SCL/SDA pair by oversampling both lines with the system clock. It decodes a 7-bit device address and exposes two byte-wide registers.

The status register sits at word address 00h. It holds three read-only gate status bits, which mirror the sequencer's primary (H), I/O (M) and core (L) gate enables, and a volatile write-enable latch. The shutdown register sits at word address FFh. It holds a 2-bit override code, which the block drives straight to the sequencer. Writes to the shutdown register only take effect while the latch is set. When a write is refused, the slave withholds the acknowledge on the data byte.

A write is one transaction: start, address byte, word address byte, a single data byte, stop. A read is a dummy write of the word address, then a repeated start with the read bit set, then one returned byte, which the master ends with a no-acknowledge and a stop. SDA is open-drain: the block only ever pulls it low.

The controller is a single state machine with these states:
- IDLE: bus free.
- ADDR: receiving the address byte.
- ADDR_ACK: acknowledging the address.
- WADDR and WADDR_ACK: receiving and acknowledging the word address.
- WDATA and WDATA_ACK: receiving the data byte and acknowledging it, or refusing it.
- TX: shifting out the read byte.
- TX_ACK: the master's acknowledge slot.
- WAIT_STOP: ignoring the bus until the next start or stop.

Its transitions are:
- Any state goes to ADDR on a start and to IDLE on a stop.
- ADDR goes to ADDR_ACK on a match and to WAIT_STOP on a mismatch, in both cases at the SCL fall after the eighth bit.
- ADDR_ACK goes to TX for a read or to WADDR for a write.
- WADDR_ACK goes to WDATA.
- WDATA_ACK goes to WAIT_STOP.
- TX goes to TX_ACK after eight bits.
- TX_ACK goes to WAIT_STOP at the next SCL rise.

Top module: `pwrseq_smb_slave`

## Requirements
- R1: The address byte is sent MSB first. It is 1010 in bits 7..4, then bits 3..1 equal to `sel_pins[2:0]`, then bit 0 as R/W (1 = read). A matching byte is acknowledged. A mismatching byte is not acknowledged, and the slave then ignores the bus until the next start or stop.
- R2: The word address byte is acknowledged. An acknowledge is SDA held low through the high phase of the ninth SCL clock. The slave changes SDA only while SCL is low.
- R3: Reading word address 00h returns {4'b0000, H status, M status, L status, latch}, with H in bit 3, M in bit 2 and L in bit 1. The H, M and L bits come from `gate_on[2]`, `gate_on[1]` and `gate_on[0]`.
- R4: The write-enable latch is 0 after reset. Writing exactly 01h to address 00h sets it. Writing any other value to 00h clears it. Writes to 00h are always acknowledged.
- R5: While the latch is set, a data byte written to FFh is acknowledged and its bits 1..0 become `shut_code`. Bits 7..2 are ignored. Reading FFh returns {6'b0, shut_code}.
- R6: While the latch is clear, a data byte written to FFh is not acknowledged and `shut_code` keeps its value.
- R7: After reset, `shut_code` is 0 and `sda_oe` is 0.
- R8: A read returns one byte, MSB first. SDA is released for the master's acknowledge slot that follows the eighth bit.
- R9: A write to any word address other than 00h or FFh is acknowledged and changes nothing. A read of such an address returns 00h.
- R10: A stop returns the slave to idle from any state. A start, including a repeated start, restarts address reception. A write cut short by a stop before its eighth data bit commits nothing.
- R11: Only one data byte is accepted per write. Any further byte in the same transaction is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| sel_pins | input | 3 | Board-strapped address select bits |
| gate_on | input | 3 | Gate enable status: bit 2 H, bit 1 M, bit 0 L |
| shut_code | output | 2 | Shutdown override code to the sequencer |

## Verification
Two functions can fall into the same transaction: committing a shutdown-register write, and detecting a stop that aborts that write. The bench provokes the collision directly. With the latch set, it sends the address and word FFh, clocks in only five data bits, and then issues a stop. It judges the outcome by `shut_code` staying put and by a later read of FFh returning the old code. A randomized mix of latch writes, shutdown writes, undefined-address accesses and reads, with random gate status, follows.

// File: rtl/pss_pkg.sv
package pss_pkg;
    typedef enum logic [3:0] {
        IDLE,
        ADDR,
        ADDR_ACK,
        WADDR,
        WADDR_ACK,
        WDATA,
        WDATA_ACK,
        TX,
        TX_ACK,
        WAIT_STOP
    } slv_state_t;

    localparam logic [7:0] STAT_WADDR = 8'h00;
    localparam logic [7:0] SHUT_WADDR = 8'hFF;
    localparam logic [7:0] WEL_SET_VAL = 8'h01;
endpackage

// File: rtl/pss_bus_sense.sv
module pss_bus_sense #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_c,
    output logic stop_c
);
    logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
    logic scl_p, sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sync <= '1;
            sda_sync <= '1;
            scl_p    <= 1'b1;
            sda_p    <= 1'b1;
        end else begin
            scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
            sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
            scl_p    <= scl_sync[SYNC_STAGES-1];
            sda_p    <= sda_sync[SYNC_STAGES-1];
        end
    end

    assign scl_s    = scl_sync[SYNC_STAGES-1];
    assign sda_s    = sda_sync[SYNC_STAGES-1];
    assign scl_rise = scl_s & ~scl_p;
    assign scl_fall = ~scl_s & scl_p;
    assign start_c  = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_c   = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/pss_regs.sv
module pss_regs #(
    parameter int DATA_W = 8,
    parameter int CODE_W = 2,
    parameter int GATES  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] ptr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [GATES-1:0]  gate_on,
    output logic              wr_blocked,
    output logic [DATA_W-1:0] rd_data,
    output logic [CODE_W-1:0] shut_code
);
    import pss_pkg::*;
    localparam int STAT_PAD = DATA_W - GATES - 1;
    localparam int CODE_PAD = DATA_W - CODE_W;

    logic              wel_q;
    logic [CODE_W-1:0] code_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wel_q  <= 1'b0;
            code_q <= '0;
        end else if (wr_stb) begin
            if (ptr == STAT_WADDR)
                wel_q <= (wdata == WEL_SET_VAL);
            else if (ptr == SHUT_WADDR && wel_q)
                code_q <= wdata[CODE_W-1:0];
        end
    end

    always_comb begin
        if (ptr == STAT_WADDR)
            rd_data = {{STAT_PAD{1'b0}}, gate_on, wel_q};
        else if (ptr == SHUT_WADDR)
            rd_data = {{CODE_PAD{1'b0}}, code_q};
        else
            rd_data = '0;
    end

    assign wr_blocked = (ptr == SHUT_WADDR) && !wel_q;
    assign shut_code  = code_q;

    // R6
    code_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code_q != $past(code_q)) |-> ($past(wel_q) && $past(wr_stb)));

    // R4
    wel_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel_q) |-> $past(wr_stb));
endmodule

// File: rtl/pwrseq_smb_slave.sv
module pwrseq_smb_slave #(
    parameter int         SEL_W       = 3,
    parameter logic [3:0] DEV_ID      = 4'b1010,
    parameter int         SYNC_STAGES = 2,
    parameter int         CODE_W      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [SEL_W-1:0]  sel_pins,
    input  logic [2:0]        gate_on,
    output logic [CODE_W-1:0] shut_code
);
    import pss_pkg::*;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    logic scl_s, sda_s, scl_rise, scl_fall, start_c, stop_c;
    logic wr_stb, wr_blocked;
    logic [BYTE_W-1:0] rd_data;

    slv_state_t        st_q, st_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [BYTE_W-1:0] sh_q, sh_d, ptr_q, ptr_d;
    logic              rw_q, rw_d, ackd_q, ackd_d;

    pss_bus_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_c(start_c), .stop_c(stop_c)
    );

    pss_regs #(.DATA_W(BYTE_W), .CODE_W(CODE_W), .GATES(3)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .ptr(ptr_q), .wdata(sh_q),
        .gate_on(gate_on), .wr_blocked(wr_blocked), .rd_data(rd_data),
        .shut_code(shut_code)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= IDLE;
            cnt_q  <= '0;
            sh_q   <= '0;
            ptr_q  <= '0;
            rw_q   <= 1'b0;
            ackd_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            sh_q   <= sh_d;
            ptr_q  <= ptr_d;
            rw_q   <= rw_d;
            ackd_q <= ackd_d;
        end
    end

    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        sh_d   = sh_q;
        ptr_d  = ptr_q;
        rw_d   = rw_q;
        ackd_d = ackd_q;
        wr_stb = 1'b0;
        if (stop_c) begin
            st_d   = IDLE;
            ackd_d = 1'b0;
        end else if (start_c) begin
            st_d   = ADDR;
            cnt_d  = '0;
            ackd_d = 1'b0;
        end else begin
            unique case (st_q)
                IDLE, WAIT_STOP: ;
                ADDR, WADDR, WDATA: begin
                    if (scl_rise && cnt_q != FULL) begin
                        sh_d  = {sh_q[BYTE_W-2:0], sda_s};
                        cnt_d = cnt_q + 1'b1;
                    end else if (scl_fall && cnt_q == FULL) begin
                        cnt_d = '0;
                        if (st_q == ADDR) begin
                            if (sh_q[7:1] == {DEV_ID, sel_pins}) begin
                                st_d   = ADDR_ACK;
                                ackd_d = 1'b1;
                                rw_d   = sh_q[0];
                            end else begin
                                st_d = WAIT_STOP;
                            end
                        end else if (st_q == WADDR) begin
                            ptr_d  = sh_q;
                            st_d   = WADDR_ACK;
                            ackd_d = 1'b1;
                        end else begin
                            wr_stb = 1'b1;
                            ackd_d = !wr_blocked;
                            st_d   = WDATA_ACK;
                        end
                    end
                end
                ADDR_ACK: if (scl_fall) begin
                    ackd_d = 1'b0;
                    cnt_d  = '0;
                    if (rw_q) begin
                        st_d = TX;
                        sh_d = rd_data;
                    end else begin
                        st_d = WADDR;
                    end
                end
                WADDR_ACK: if (scl_fall) begin
                    ackd_d = 1'b0;
                    st_d   = WDATA;
                end
                WDATA_ACK: if (scl_fall) begin
                    ackd_d = 1'b0;
                    st_d   = WAIT_STOP;
                end
                TX: if (scl_fall) begin
                    if (cnt_q == LAST) begin
                        st_d = TX_ACK;
                    end else begin
                        sh_d  = {sh_q[BYTE_W-2:0], 1'b0};
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                TX_ACK: if (scl_rise) st_d = WAIT_STOP;
            endcase
        end
    end

    always_comb begin
        sda_oe = 1'b0;
        if (st_q inside {ADDR_ACK, WADDR_ACK, WDATA_ACK})
            sda_oe = ackd_q;
        else if (st_q == TX)
            sda_oe = !sh_q[BYTE_W-1];
    end

    // R10
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_c |=> (st_q == IDLE));

    // R10
    start_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_c |=> (st_q == ADDR && cnt_q == '0));

    // R2
    sda_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && !scl_rise) |-> $stable(sda_oe));

    // R1
    bit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL);
endmodule

// File: tb/sim_pwrseq_smb_slave.sv
module sim_pwrseq_smb_slave;
    localparam int Q = 8;
    localparam logic [2:0] PINS = 3'b101;
    localparam logic [6:0] DEV = {4'b1010, PINS};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic [2:0] gate_on = 3'b000;
    logic sda_oe;
    logic [1:0] shut_code;
    wire sda_line = sda_oe ? 1'b0 : m_sda;

    int checks = 0, errors = 0;
    bit done = 0;
    logic wel_m = 1'b0;
    logic [1:0] code_m = 2'b00;

    always #10 clk = ~clk;

    pwrseq_smb_slave u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
        .sda_oe(sda_oe), .sel_pins(PINS), .gate_on(gate_on), .shut_code(shut_code)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic hp(); repeat (Q) @(negedge clk); endtask
    task automatic gap(); repeat (2) @(negedge clk); endtask

    task automatic bus_start();
        m_sda = 1; hp(); m_scl = 1; hp(); m_sda = 0; hp(); m_scl = 0; gap();
    endtask

    task automatic bus_stop();
        m_sda = 0; hp(); m_scl = 1; hp(); m_sda = 1; hp();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; hp(); m_scl = 1; hp(); m_scl = 0; gap();
        end
        m_sda = 1; hp(); m_scl = 1; hp();
        ack = !sda_line;
        m_scl = 0; gap();
    endtask

    task automatic recv_byte(output logic [7:0] b, output logic rel);
        for (int i = 7; i >= 0; i--) begin
            m_sda = 1; hp(); m_scl = 1; hp(); b[i] = sda_line; m_scl = 0; gap();
        end
        m_sda = 1; hp(); m_scl = 1; hp();
        rel = sda_line;
        m_scl = 0; gap();
    endtask

    function automatic logic [7:0] exp_read(input logic [7:0] a);
        if (a == 8'h00) return {4'b0, gate_on, wel_m};
        if (a == 8'hFF) return {6'b0, code_m};
        return 8'h00;
    endfunction

    task automatic wr_reg(input logic [7:0] a, input logic [7:0] d,
                          output logic k0, output logic k1, output logic k2);
        k1 = 0; k2 = 0;
        bus_start();
        send_byte({DEV, 1'b0}, k0);
        if (k0) begin
            send_byte(a, k1);
            send_byte(d, k2);
        end
        bus_stop();
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [7:0] d, output logic ok, output logic rel);
        logic k0, k1, k2;
        bus_start();
        send_byte({DEV, 1'b0}, k0);
        send_byte(a, k1);
        bus_start();
        send_byte({DEV, 1'b1}, k2);
        recv_byte(d, rel);
        bus_stop();
        ok = k0 & k1 & k2;
    endtask

    task automatic model_write(input logic [7:0] a, input logic [7:0] d, output logic exp_dack);
        exp_dack = 1;
        if (a == 8'h00) wel_m = (d == 8'h01);
        else if (a == 8'hFF) begin
            exp_dack = wel_m;
            if (wel_m) code_m = d[1:0];
        end
    endtask

    task automatic do_write(input string req, input logic [7:0] a, input logic [7:0] d);
        logic k0, k1, k2, e;
        wr_reg(a, d, k0, k1, k2);
        model_write(a, d, e);
        chk({req, " addr ack"}, {31'b0, k0}, 1);
        chk({req, " word ack"}, {31'b0, k1}, 1);
        chk({req, " data ack"}, {31'b0, k2}, {31'b0, e});
        chk({req, " code"}, {30'b0, shut_code}, {30'b0, code_m});
    endtask

    task automatic do_read(input string req, input logic [7:0] a);
        logic [7:0] d;
        logic ok, rel;
        rd_reg(a, d, ok, rel);
        chk({req, " acks"}, {31'b0, ok}, 1);
        chk({req, " data"}, {24'b0, d}, {24'b0, exp_read(a)});
        chk("R8 release", {31'b0, rel}, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic k0, k1, k2;
        logic [31:0] r;
        r = $urandom(32'd1977);
        repeat (5) @(negedge clk);
        chk("R7 sda_oe reset", {31'b0, sda_oe}, 0);
        chk("R7 code reset", {30'b0, shut_code}, 0);
        rst_n = 1;
        repeat (5) @(negedge clk);

        gate_on = 3'b101;
        do_read("R3 R4 status after reset", 8'h00);

        // R1 wrong identifier, then wrong select pins
        bus_start(); send_byte({4'b1011, PINS, 1'b0}, k0); bus_stop();
        chk("R1 bad id nack", {31'b0, k0}, 0);
        bus_start(); send_byte({4'b1010, 3'b011, 1'b0}, k0); bus_stop();
        chk("R1 bad pins nack", {31'b0, k0}, 0);

        do_write("R6 blocked", 8'hFF, 8'h03);
        do_write("R4 set latch", 8'h00, 8'h01);
        gate_on = 3'b010;
        do_read("R3 R4 status latch", 8'h00);
        do_write("R5 code write", 8'hFF, 8'hFE);
        chk("R5 code port", {30'b0, shut_code}, 2);
        do_read("R5 code read", 8'hFF);
        do_write("R9 undefined write", 8'h5A, 8'hFF);
        do_read("R9 undefined read", 8'h5A);

        // R10 write aborted by stop after five data bits
        bus_start();
        send_byte({DEV, 1'b0}, k0);
        send_byte(8'hFF, k1);
        for (int i = 0; i < 5; i++) begin
            m_sda = 1; hp(); m_scl = 1; hp(); m_scl = 0; gap();
        end
        bus_stop();
        chk("R10 aborted write code", {30'b0, shut_code}, {30'b0, code_m});
        do_read("R10 after abort", 8'hFF);

        // R11 second data byte refused
        bus_start();
        send_byte({DEV, 1'b0}, k0);
        send_byte(8'hFF, k1);
        send_byte(8'h01, k2);
        model_write(8'hFF, 8'h01, k0);
        send_byte(8'h03, k2);
        bus_stop();
        chk("R11 extra byte nack", {31'b0, k2}, 0);
        chk("R11 code", {30'b0, shut_code}, {30'b0, code_m});

        do_write("R4 clear latch", 8'h00, 8'h03);
        do_write("R6 blocked again", 8'hFF, 8'h02);
        do_read("R4 cleared", 8'h00);

        for (int n = 0; n < 40; n++) begin
            logic [7:0] a, d;
            int op;
            gate_on = 3'($urandom());
            op = int'($urandom_range(0, 5));
            d = 8'($urandom());
            a = 8'($urandom_range(1, 254));
            unique case (op)
                0: do_write("R4 rand latch", 8'h00, ($urandom_range(0, 1) == 1) ? 8'h01 : d);
                1: do_write("R5 R6 rand code", 8'hFF, d);
                2: do_write("R9 rand undefined", a, d);
                3: do_read("R3 rand status", 8'h00);
                4: do_read("R5 rand code", 8'hFF);
                default: do_read("R9 rand undefined", a);
            endcase
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule